// File: doc/BRIEF.md
# Stack-Based Operand Processor Core

This core runs a small program held in a byte-addressed memory of up to 64 KB. It keeps its operands in an internal last-in first-out stack of 16-bit words. Only two instructions touch data memory. One loads a little-endian word from a 16-bit address onto the stack. The other stores the top word to a 16-bit address and removes it. The four arithmetic instructions carry no address. Each one takes the two uppermost stack words and leaves a single result in their place. A halt instruction ends the run.

The opcode's bit 7 sets the instruction length. When it is set, two address bytes follow the opcode, low byte first. When it is clear, the instruction is the opcode byte alone. The memory port moves one byte per cycle, and read data must be returned in the same cycle as the address. A pulse on `start` clears the stack, sets the program counter to 0x0000 and begins fetching. `done` reports that the run has stopped. `error` reports that it stopped on a fault: a push onto a full stack, too few words for a store or an arithmetic operation, a zero divisor, or an undefined opcode. The current top word and the stack depth can be read at all times.

Top module: `stk_core`

## Requirements
- R1: After reset, `done`, `error` and `mem_we` are 0, `depth` is 0 and `tos` reads 0. `tos` also reads 0 whenever the stack is empty.
- R2: Opcode 0x80, followed by address bytes lo and hi, reads the byte at A={hi,lo} as the low half and the byte at A+1 as the high half. It pushes that word, so `depth` rises by one and `tos` shows the word. It takes 5 cycles.
- R3: Opcode 0x81, followed by an address A, writes the low byte of the top word to A and then its high byte to A+1, on two consecutive cycles. It then removes that word. It takes 5 cycles.
- R4: Opcode 0x01 (add) and opcode 0x03 (multiply) replace the two top words with the low 16 bits of their sum or product. `depth` falls by one. Each takes 2 cycles.
- R5: Opcode 0x02 (subtract) and opcode 0x04 (divide) use the second word as the left operand and the top word as the right one. Divide is signed two's complement and truncates toward zero.
- R6: The stack is strictly last-in first-out: a store always takes the most recently pushed word still on the stack.
- R7: When bit 7 of the opcode is set, the instruction is 3 bytes long; when it is clear, it is 1 byte long. The program counter starts at 0x0000 and steps over each instruction by its length.
- R8: Opcode 0x00 (halt) sets `done` and leaves `error` at 0. While halted, no memory write occurs and the outputs hold until the next `start`.
- R9: A push when the stack holds 16 words sets `error` and `done`, and leaves the stack unchanged.
- R10: A store on an empty stack, or an arithmetic opcode with fewer than two words on the stack, sets `error` and `done`, and leaves the stack unchanged.
- R11: Divide with a top word of zero sets `error` and `done`, and leaves both operands on the stack.
- R12: Any opcode other than 0x00 to 0x04, 0x80 and 0x81 sets `error` and `done`.
- R13: `start` is honoured only while idle or halted. It clears `done`, `error` and the stack on the following edge. While a program is running, `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run from address 0x0000 |
| mem_addr | output | 16 | Byte address for the current memory access |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one byte per cycle |
| done | output | 1 | The run has stopped, either by halt or by a fault |
| error | output | 1 | The run stopped because of a fault |
| tos | output | 16 | Top stack word, or 0 when the stack is empty |
| depth | output | 5 | Number of words on the stack |

## Verification
The assertions check on every cycle that the stack is never pushed when full and never popped or folded below its contents. They also check that a push shows its word on top, that a store reveals the word beneath, and that the two bytes of a store go to consecutive addresses. In addition, they check that a halted core stays still and that a zero divisor or an undefined opcode traps. Whether the arithmetic values are right, whether operand order and signed truncation hold, and whether whole programs keep their cycle timing can only be shown by the bench. Its instruction-level model follows every clock through programs that evaluate an expression, reach the stack limits and trip each fault.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam byte_t OP_HALT = 8'h00;
    localparam byte_t OP_ADD  = 8'h01;
    localparam byte_t OP_SUB  = 8'h02;
    localparam byte_t OP_MUL  = 8'h03;
    localparam byte_t OP_DIV  = 8'h04;
    localparam byte_t OP_PUSH = 8'h80;
    localparam byte_t OP_POP  = 8'h81;

    typedef enum logic [2:0] {
        SC_NONE, SC_PUSH, SC_POP, SC_FOLD, SC_CLEAR
    } stk_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_ALO, ST_AHI, ST_DLO, ST_DHI,
        ST_WLO, ST_WHI, ST_EXEC, ST_HALT
    } ctrl_state_e;

    typedef struct packed {
        byte_t opcode;
        addr_t addr;
    } instr_t;

    function automatic logic op_is_long(byte_t op);
        return op[BYTE_W-1];
    endfunction

    function automatic logic op_is_arith(byte_t op);
        return (op >= OP_ADD) && (op <= OP_DIV);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  byte_t opcode,
    input  word_t left,
    input  word_t right,
    output word_t result,
    output logic  div_zero
);
    logic [2*WORD_W-1:0] prod;

    assign div_zero = (opcode == OP_DIV) && (right == '0);

    always_comb begin
        prod = (2*WORD_W)'(left) * (2*WORD_W)'(right);
        case (opcode)
            OP_ADD:  result = left + right;
            OP_SUB:  result = left - right;
            OP_MUL:  result = prod[WORD_W-1:0];
            OP_DIV:  result = div_zero ? '0 : word_t'($signed(left) / $signed(right));
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/stk_stack.sv
module stk_stack
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_cmd_e      cmd,
    input  word_t         din,
    output word_t         tos,
    output word_t         nos,
    output logic [DW-1:0] depth
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t slots [DEPTH];
    logic [AW-1:0] top_idx, sec_idx, new_idx;

    assign top_idx = AW'(depth - DW'(1));
    assign sec_idx = AW'(depth - DW'(2));
    assign new_idx = AW'(depth);

    assign tos = (depth == '0) ? '0 : slots[top_idx];
    assign nos = (depth < DW'(2)) ? '0 : slots[sec_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else begin
            case (cmd)
                SC_PUSH:  depth <= depth + DW'(1);
                SC_POP:   depth <= depth - DW'(1);
                SC_FOLD:  depth <= depth - DW'(1);
                SC_CLEAR: depth <= '0;
                default:  depth <= depth;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (cmd == SC_PUSH) slots[new_idx] <= din;
        else if (cmd == SC_FOLD) slots[sec_idx] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_PUSH) |-> (depth < DW'(DEPTH)));                    // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_POP) |-> (depth != '0));                            // R10
    AST_FOLD_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_FOLD) |-> (depth >= DW'(2)));                       // R10
    AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_PUSH) |=> (tos == $past(din)) && (depth == $past(depth) + DW'(1))); // R2
    AST_POP_REVEALS: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_POP && depth >= DW'(2)) |=> (tos == $past(nos)));   // R6
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  byte_t         mem_rdata,
    input  logic [DW-1:0] depth,
    input  word_t         tos,
    input  word_t         alu_result,
    input  logic          div_zero,
    output addr_t         mem_addr,
    output byte_t         mem_wdata,
    output logic          mem_we,
    output stk_cmd_e      stk_cmd,
    output word_t         stk_din,
    output byte_t         opcode,
    output logic          done,
    output logic          error
);
    ctrl_state_e state;
    addr_t       pc;
    instr_t      ins;
    byte_t       lo;
    logic        exec_ok, push_ok, pop_ok;

    assign opcode  = ins.opcode;
    assign exec_ok = op_is_arith(ins.opcode) && (depth >= DW'(2)) && !div_zero;
    assign push_ok = (ins.opcode == OP_PUSH) && (depth < DW'(DEPTH));
    assign pop_ok  = (ins.opcode == OP_POP) && (depth != '0);

    always_comb begin
        mem_addr  = pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        stk_cmd   = SC_NONE;
        stk_din   = alu_result;
        case (state)
            ST_IDLE, ST_HALT: if (start) stk_cmd = SC_CLEAR;
            ST_DLO: mem_addr = ins.addr;
            ST_DHI: begin
                mem_addr = ins.addr + addr_t'(1);
                stk_cmd  = SC_PUSH;
                stk_din  = {mem_rdata, lo};
            end
            ST_WLO: begin
                mem_addr  = ins.addr;
                mem_we    = 1'b1;
                mem_wdata = tos[BYTE_W-1:0];
            end
            ST_WHI: begin
                mem_addr  = ins.addr + addr_t'(1);
                mem_we    = 1'b1;
                mem_wdata = tos[WORD_W-1:BYTE_W];
                stk_cmd   = SC_POP;
            end
            ST_EXEC: if (exec_ok) stk_cmd = SC_FOLD;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= '0;
            ins   <= '0;
            lo    <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_HALT: if (start) begin
                    pc    <= '0;
                    done  <= 1'b0;
                    error <= 1'b0;
                    state <= ST_FETCH;
                end
                ST_FETCH: begin
                    ins.opcode <= mem_rdata;
                    pc         <= pc + addr_t'(1);
                    state      <= op_is_long(mem_rdata) ? ST_ALO : ST_EXEC;
                end
                ST_ALO: begin
                    ins.addr[BYTE_W-1:0] <= mem_rdata;
                    pc    <= pc + addr_t'(1);
                    state <= ST_AHI;
                end
                ST_AHI: begin
                    ins.addr[ADDR_W-1:BYTE_W] <= mem_rdata;
                    pc <= pc + addr_t'(1);
                    if (push_ok) state <= ST_DLO;
                    else if (pop_ok) state <= ST_WLO;
                    else begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_HALT;
                    end
                end
                ST_DLO: begin
                    lo    <= mem_rdata;
                    state <= ST_DHI;
                end
                ST_WLO: state <= ST_WHI;
                ST_DHI, ST_WHI: state <= ST_FETCH;
                ST_EXEC: begin
                    if (ins.opcode == OP_HALT) begin
                        done  <= 1'b1;
                        state <= ST_HALT;
                    end else if (exec_ok) begin
                        state <= ST_FETCH;
                    end else begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_HALT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !start) |=> (state == ST_HALT) && !mem_we && $stable(done) && $stable(error)); // R8
    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WLO) |=> mem_we && (mem_addr == $past(mem_addr) + addr_t'(1)));                       // R3
    AST_DIV_ZERO_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && div_zero) |=> error && done);                                                   // R11
    AST_UNKNOWN_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !op_is_arith(ins.opcode) && ins.opcode != OP_HALT) |=> error);                  // R12
    AST_LONG_FORM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && mem_rdata[BYTE_W-1]) |=> (mem_addr == $past(mem_addr) + addr_t'(1)));          // R7
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter  int STACK_DEPTH = 16,
    localparam int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [15:0]        mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic [7:0]         mem_wdata,
    output logic               mem_we,
    output logic               done,
    output logic               error,
    output logic [15:0]        tos,
    output logic [DEPTH_W-1:0] depth
);
    stk_cmd_e stk_cmd;
    word_t    stk_din, nos, alu_result;
    byte_t    opcode;
    logic     div_zero;

    stk_stack #(.DEPTH(STACK_DEPTH), .DW(DEPTH_W)) u_stack (
        .clk(clk), .rst(rst), .cmd(stk_cmd), .din(stk_din),
        .tos(tos), .nos(nos), .depth(depth)
    );

    stk_alu u_alu (
        .opcode(opcode), .left(nos), .right(tos),
        .result(alu_result), .div_zero(div_zero)
    );

    stk_ctrl #(.DEPTH(STACK_DEPTH), .DW(DEPTH_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
        .depth(depth), .tos(tos), .alu_result(alu_result), .div_zero(div_zero),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .stk_cmd(stk_cmd), .stk_din(stk_din), .opcode(opcode),
        .done(done), .error(error)
    );
endmodule

// File: tb/stk_core_bench.sv
module stk_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we, done, error;
    logic [15:0] tos;
    logic [4:0]  depth;

    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;

    logic [7:0]  b_mem [4096];
    logic [7:0]  m_mem [4096];

    int n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0;
    int pa = 0;

    // reference model state
    int     m_stk[$];
    bit     m_busy = 0, m_done = 0, m_err = 0;
    int     m_left = 0;
    logic [15:0] m_pc = '0;

    always #2 clk = ~clk;

    stk_core u_stk_core (
        .clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .done(done), .error(error), .tos(tos), .depth(depth)
    );

    assign mem_rdata = b_mem[mem_addr[11:0]];

    function automatic logic [7:0] mrd(logic [15:0] a);
        return m_mem[a[11:0]];
    endfunction

    task automatic m_fault();
        m_err = 1; m_done = 1; m_busy = 0;
    endtask

    task automatic m_apply();
        logic [7:0]  op;
        logic [15:0] a;
        int l, r, res;
        op = mrd(m_pc);
        if (op[7]) begin
            a = {mrd(m_pc + 16'd2), mrd(m_pc + 16'd1)};
            m_pc = m_pc + 16'd3;
            if (op == 8'h80 && m_stk.size() < 16)
                m_stk.push_back({mrd(a + 16'd1), mrd(a)});
            else if (op == 8'h81 && m_stk.size() > 0) begin
                r = m_stk.pop_back();
                m_mem[a[11:0]] = r[7:0];
                a = a + 16'd1;
                m_mem[a[11:0]] = r[15:8];
            end else m_fault();
        end else begin
            m_pc = m_pc + 16'd1;
            if (op == 8'h00) begin m_done = 1; m_busy = 0; end
            else if (op >= 8'h01 && op <= 8'h04) begin
                if (m_stk.size() < 2) m_fault();
                else if (op == 8'h04 && m_stk[$] == 0) m_fault();
                else begin
                    r = m_stk.pop_back();
                    l = m_stk.pop_back();
                    case (op)
                        8'h01: res = l + r;
                        8'h02: res = l - r;
                        8'h03: res = int'((longint'(l) * longint'(r)) & 64'hFFFF);
                        default: res = int'(shortint'(l[15:0])) / int'(shortint'(r[15:0]));
                    endcase
                    m_stk.push_back(res & 32'hFFFF);
                end
            end else m_fault();
        end
    endtask

    always @(posedge clk) begin
        if (ld_we) begin
            b_mem[ld_addr] <= ld_data;
            m_mem[ld_addr] = ld_data;
        end else if (mem_we) b_mem[mem_addr[11:0]] <= mem_wdata;

        if (rst) begin
            m_busy = 0; m_done = 0; m_err = 0; m_left = 0; m_pc = '0;
            m_stk.delete();
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_done = 0; m_err = 0; m_left = 0; m_pc = '0;
                m_stk.delete();
            end
        end else begin
            if (m_left == 0) begin
                logic [7:0] op;
                op = mrd(m_pc);
                if (!op[7]) m_left = 2;
                else if ((op == 8'h80 && m_stk.size() < 16) || (op == 8'h81 && m_stk.size() > 0)) m_left = 5;
                else m_left = 3;
            end
            m_left = m_left - 1;
            if (m_left == 0) m_apply();
        end
    end

    // per-cycle comparison against the model (R2/R3/R4/R5/R6/R7 timing and values)
    always @(negedge clk) begin
        if (!rst) begin
            int et;
            et = (m_stk.size() == 0) ? 0 : m_stk[$];
            c_chk++;
            if (tos !== 16'(et) || depth !== 5'(m_stk.size()) || done !== m_done || error !== m_err) begin
                c_fail++;
                $display("FAIL R7 cycle: tos=%h depth=%0d done=%b err=%b expected tos=%h depth=%0d done=%b err=%b",
                         tos, depth, done, error, 16'(et), m_stk.size(), m_done, m_err);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic poke(int a, int d);
        ld_we = 1; ld_addr = 12'(a); ld_data = 8'(d);
        @(negedge clk);
        ld_we = 0;
    endtask

    task automatic emit(int b);  poke(pa, b); pa++; endtask
    task automatic i_long(int op, int a); emit(op); emit(a & 255); emit((a >> 8) & 255); endtask
    task automatic put_word(int a, int v); poke(a, v & 255); poke(a + 1, (v >> 8) & 255); endtask
    function automatic int get_word(int a); return {b_mem[12'(a + 1)], b_mem[12'(a)]}; endfunction

    task automatic run(int poke_mid);
        int n;
        start = 1; @(negedge clk); start = 0;
        chk("R13 cleared on start", {29'd0, done, error, |depth}, 0);
        n = 0;
        while (!(done === 1'b1 && !m_busy) && n < 3000) begin
            @(negedge clk); n++;
            if (n == poke_mid) begin start = 1; @(negedge clk); start = 0; end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        chk("R1 reset done", done, 0);
        chk("R1 reset error", error, 0);
        chk("R1 reset depth", depth, 0);
        chk("R1 reset tos", tos, 0);
        chk("R1 reset we", mem_we, 0);

        // expression b*(c + d*e - f/g), stray start mid-run (R13)
        put_word('h100, 3); put_word('h102, 10); put_word('h104, 4);
        put_word('h106, 5); put_word('h108, 'hFFEC); put_word('h10A, 3);
        pa = 0;
        i_long('h80, 'h100); i_long('h80, 'h102); i_long('h80, 'h104); i_long('h80, 'h106);
        emit('h03); emit('h01);
        i_long('h80, 'h108); i_long('h80, 'h10A);
        emit('h04); emit('h02); emit('h03);
        i_long('h81, 'h10C); emit('h00);
        run(7);
        chk("R5 expression result", get_word('h10C), 108);
        chk("R8 halt no error", error, 0);
        chk("R3 stack empty after store", depth, 0);
        repeat (4) @(negedge clk);
        chk("R8 done holds", done, 1);
        chk("R8 no write while halted", mem_we, 0);

        // low-half multiply, ordered subtract, signed divide, LIFO
        put_word('h110, 'h1234); put_word('h112, 'h0100);
        put_word('h114, 5); put_word('h116, 9);
        put_word('h118, 'hFFF9); put_word('h11A, 2);
        put_word('h11C, 'h1111); put_word('h11E, 'h2222);
        pa = 0;
        i_long('h80, 'h110); i_long('h80, 'h112); emit('h03); i_long('h81, 'h120);
        i_long('h80, 'h114); i_long('h80, 'h116); emit('h02); i_long('h81, 'h122);
        i_long('h80, 'h118); i_long('h80, 'h11A); emit('h04); i_long('h81, 'h124);
        i_long('h80, 'h114); i_long('h80, 'h116); emit('h01); i_long('h81, 'h12A);
        i_long('h80, 'h11C); i_long('h80, 'h11E); i_long('h81, 'h126); i_long('h81, 'h128);
        emit('h00);
        run(0);
        chk("R4 multiply low half", get_word('h120), 'h3400);
        chk("R4 add", get_word('h12A), 14);
        chk("R5 subtract order", get_word('h122), 'hFFFC);
        chk("R5 signed truncating divide", get_word('h124), 'hFFFD);
        chk("R6 last pushed stored first", get_word('h126), 'h2222);
        chk("R6 earlier word stored second", get_word('h128), 'h1111);

        // overflow: 17 pushes
        pa = 0;
        for (int i = 0; i < 17; i++) i_long('h80, 'h114);
        emit('h00);
        run(0);
        chk("R9 overflow error", error, 1);
        chk("R9 depth kept at full", depth, 16);
        chk("R9 top unchanged", tos, 5);

        // store on empty stack
        pa = 0; i_long('h81, 'h130); emit('h00);
        put_word('h130, 'hABCD);
        run(0);
        chk("R10 store empty error", error, 1);
        chk("R10 memory untouched", get_word('h130), 'hABCD);

        // arithmetic with one word
        pa = 0; i_long('h80, 'h116); emit('h01); emit('h00);
        run(0);
        chk("R10 short operands error", error, 1);
        chk("R10 stack kept", depth, 1);
        chk("R10 top kept", tos, 9);

        // zero divisor
        put_word('h132, 0);
        pa = 0; i_long('h80, 'h116); i_long('h80, 'h132); emit('h04); emit('h00);
        run(0);
        chk("R11 divide by zero error", error, 1);
        chk("R11 operands kept", depth, 2);

        // undefined short and long opcodes
        pa = 0; emit('h05); emit('h00);
        run(0);
        chk("R12 undefined short opcode", error, 1);
        pa = 0; i_long('h90, 'h130); emit('h00);
        run(0);
        chk("R12 undefined long opcode", error, 1);
        chk("R12 done set", done, 1);

        // clean rerun after a fault
        pa = 0; emit('h00);
        run(0);
        chk("R13 rerun clears error", error, 0);
        chk("R13 rerun done", done, 1);

        $display("%0d/%0d checks passed", (n_chk + c_chk) - (n_fail + c_fail), n_chk + c_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected finished");
        $display("%0d/%0d checks passed", (n_chk + c_chk) - (n_fail + c_fail), n_chk + c_chk);
        $finish;
    end
endmodule